// File: doc/BRIEF.md
# Two-Wire Slave for a 16-bit Register Bank

This block is the slave end of a two-wire serial bus (I2C-style) that reaches a bank of 16-bit registers through an 8-bit register pointer. It samples the clock and data lines into the system clock domain and picks out start, repeated start and stop conditions. It then decodes a fixed 7-bit device address with its read/write bit. The data line is driven open-drain style: the block only pulls it low through an output enable.

A write transfer carries the register pointer and then any number of 16-bit words. Each word is sent as a high byte followed by a low byte. A word reaches the register file only when both of its bytes have arrived. The pointer steps by one after every complete word, so a burst fills consecutive registers.

A read transfer first sets the pointer with a short write. The master then sends a repeated start with the read address. The slave returns words high byte first, for as long as the master acknowledges, and steps the pointer after each word. The register storage sits outside the block, behind a one-cycle write port and a combinational read port.

Top module: `twi_reg16_slave`

## Requirements
- R1: While reset is asserted and directly after it, the block does not pull the data line (sda_oe = 0) and issues no register write.
- R2: The block acknowledges an address byte of 0xBA (write) or 0xBB (read), i.e. 7-bit address 0x5D with R/W in bit 0, by pulling the data line low during the ninth clock of that byte.
- R3: After an address byte that does not match, the block sends no acknowledge, drives nothing and writes nothing until the next start condition.
- R4: In a write transfer the block acknowledges the pointer byte and every data byte. After each high/low byte pair it issues exactly one write pulse carrying {high, low} to the current pointer.
- R5: A high byte that is not followed by its low byte produces no write, whether the transfer ends with a stop or with a repeated start.
- R6: After each complete written word the pointer increments, so successive word pairs in one transfer go to consecutive registers.
- R7: After a pointer write, a repeated start and address 0xBB, the block returns the addressed register's high byte and then its low byte, most significant bit first.
- R8: During a read the pointer increments after each 16 bits sent, including a word that ends in a no-acknowledge. Further acknowledged words therefore come from consecutive registers.
- R9: When the master does not acknowledge a read byte, the block releases the data line and leaves it released until the next start.
- R10: The pointer wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Pull the data line low when 1 |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register index for the write |
| reg_wr_data | output | 16 | Word to write |
| reg_rd_addr | output | 8 | Current register pointer, used as read index |
| reg_rd_data | input | 16 | Word at reg_rd_addr, combinational |

## Verification
A wrong byte phase or bit count shows up on the bus within one byte time. An acknowledge goes missing or lands on the wrong clock, or a read byte comes back shifted. A pointer that steps at the wrong moment is not seen at once. It appears on the next word of a burst, when data lands in or comes from the neighbouring register. A stale half-word shows as a spurious write strobe at the end of the aborted transfer, so the bench counts strobes and reads the registers back over the bus.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_REG,
    PH_HI,
    PH_LO
  } twi_phase_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D,
  parameter int         REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);
  localparam int LAST_BIT = BYTE_W - 1;

  twi_state_e state_q, state_d;
  twi_phase_e phase_q, phase_d;
  logic [2:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, hi_q, hi_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [REG_AW-1:0] ptr_q, ptr_d, wa_q, wa_d;
  logic [WORD_W-1:0] wd_q, wd_d;
  logic              end_q, end_d, ack_q, ack_d, rdm_q, rdm_d, mack_q, mack_d;
  logic              oe_q, oe_d, we_q, we_d;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_d = state_q; phase_d = phase_q; cnt_d = cnt_q; sh_d = sh_q;
    hi_d = hi_q; word_d = word_q; ptr_d = ptr_q; wa_d = wa_q; wd_d = wd_q;
    end_d = end_q; ack_d = ack_q; rdm_d = rdm_q; mack_d = mack_q;
    oe_d = oe_q; we_d = 1'b0;
    if (bus_start) begin
      state_d = ST_RX; phase_d = PH_DEV; cnt_d = '0; end_d = 1'b0; oe_d = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE; end_d = 1'b0; oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'(LAST_BIT)) begin
              end_d = 1'b1;
              ack_d = 1'b1;
              unique case (phase_q)
                PH_DEV: begin
                  ack_d   = (rx_byte[7:1] == DEV_ADDR);
                  rdm_d   = rx_byte[0];
                  phase_d = rx_byte[0] ? PH_HI : PH_REG;
                end
                PH_REG: begin
                  ptr_d   = REG_AW'(rx_byte);
                  phase_d = PH_HI;
                end
                PH_HI: begin
                  hi_d    = rx_byte;
                  phase_d = PH_LO;
                end
                PH_LO: begin
                  we_d    = 1'b1;
                  wa_d    = ptr_q;
                  wd_d    = {hi_q, rx_byte};
                  ptr_d   = ptr_q + 1'b1;
                  phase_d = PH_HI;
                end
                default: ;
              endcase
            end
          end else if (scl_fall && end_q) begin
            end_d = 1'b0;
            if (ack_q) begin
              state_d = ST_RX_ACK; oe_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rdm_q) begin
              state_d = ST_TX;
              word_d  = rd_data;
              sh_d    = rd_data[WORD_W-1 -: BYTE_W];
              oe_d    = ~rd_data[WORD_W-1];
            end else begin
              state_d = ST_RX; oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'(LAST_BIT)) begin
              end_d = 1'b1;
              if (phase_q == PH_LO) ptr_d = ptr_q + 1'b1;
              phase_d = (phase_q == PH_HI) ? PH_LO : PH_HI;
            end
          end else if (scl_fall) begin
            if (end_q) begin
              end_d = 1'b0; oe_d = 1'b0; mack_d = 1'b0; state_d = ST_TX_ACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_s) state_d = ST_IDLE;
            else       mack_d  = 1'b1;
          end else if (scl_fall && mack_q) begin
            state_d = ST_TX; cnt_d = '0;
            if (phase_q == PH_HI) begin
              word_d = rd_data;
              sh_d   = rd_data[WORD_W-1 -: BYTE_W];
              oe_d   = ~rd_data[WORD_W-1];
            end else begin
              sh_d = word_q[BYTE_W-1:0];
              oe_d = ~word_q[BYTE_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; phase_q <= PH_DEV; cnt_q <= '0; sh_q <= '0;
      hi_q <= '0; word_q <= '0; ptr_q <= '0; wa_q <= '0; wd_q <= '0;
      end_q <= 1'b0; ack_q <= 1'b0; rdm_q <= 1'b0; mack_q <= 1'b0;
      oe_q <= 1'b0; we_q <= 1'b0;
    end else begin
      state_q <= state_d; phase_q <= phase_d; cnt_q <= cnt_d; sh_q <= sh_d;
      hi_q <= hi_d; word_q <= word_d; ptr_q <= ptr_d; wa_q <= wa_d; wd_q <= wd_d;
      end_q <= end_d; ack_q <= ack_d; rdm_q <= rdm_d; mack_q <= mack_d;
      oe_q <= oe_d; we_q <= we_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign rd_addr = ptr_q;

  // R4: a write strobe is always the result of a clock rise seen one cycle before
  a_r4_write_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_rise));
  // R6: the pointer has already moved past the word being written
  a_r6_ptr_advanced: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_addr == REG_AW'(wr_addr + 1'b1)));
  // R9: when parked, the data line is never pulled
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);
  // R2: the drive on the data line only changes while the clock is low
  a_r2_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R3: an unacknowledged byte never leads into an acknowledge slot
  a_r3_no_ack_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX && end_q && !ack_q) |=> (state_q != ST_RX_ACK));
endmodule

// File: rtl/twi_reg16_slave.sv
module twi_reg16_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h5D,
  parameter int         REG_AW      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [15:0]       reg_wr_data,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [15:0]       reg_rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
  twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

  twi_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop));

  twi_slave_fsm #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_oe(sda_oe), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data));

  // R1: no drive and no write strobe right out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_oe && !reg_wr_en));
endmodule

// File: tb/twi_reg16_slave_tb.sv
module twi_reg16_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic line;
  logic [15:0] mem [256];
  int wr_cnt = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign line = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];

  twi_reg16_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_addr(rd_addr), .reg_rd_data(rd_data));

  function automatic logic [15:0] init_val(input int i);
    return 16'((i * 16'h0101) ^ 16'hA5A5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(4); sda_m = b; tick(6); scl_m = 1'b1; tick(10); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    tick(4); sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(5); v = line; tick(5); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    tick(4); sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(4); sda_m = 1'b0; tick(6); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(v);
    acked = ~v;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(~give_ack);
  endtask

  task automatic set_ptr(input string tag, input logic [7:0] p);
    logic a;
    bus_start();
    wr_byte(8'hBA, a); chk({tag, " R2 write addr ack"}, 16'(a), 16'h1);
    wr_byte(p, a);     chk({tag, " R4 pointer ack"}, 16'(a), 16'h1);
  endtask

  task automatic send_word(input string tag, input logic [15:0] w);
    logic a1, a2;
    wr_byte(w[15:8], a1);
    wr_byte(w[7:0], a2);
    chk({tag, " R4 data acks"}, {14'h0, a1, a2}, 16'h3);
  endtask

  task automatic read_word(output logic [15:0] w, input logic last_ack);
    logic [7:0] h, l;
    rd_byte(h, 1'b1);
    rd_byte(l, last_ack);
    w = {h, l};
  endtask

  task automatic t_reset();
    chk("R1 sda_oe in reset", 16'(sda_oe), 16'h0);
    chk("R1 wr_en in reset", 16'(wr_en), 16'h0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 sda_oe after reset", 16'(sda_oe), 16'h0);
    chk("R1 no write after reset", 16'(wr_cnt), 16'h0);
  endtask

  task automatic t_write_one();
    int c0 = wr_cnt;
    set_ptr("wr1", 8'h09);
    send_word("wr1", 16'h0284);
    bus_stop();
    chk("R4 single word stored", mem[8'h09], 16'h0284);
    chk("R4 one strobe per word", 16'(wr_cnt - c0), 16'h1);
  endtask

  task automatic t_read_one();
    logic a;
    logic [15:0] w;
    set_ptr("rd1", 8'h09);
    bus_start();
    wr_byte(8'hBB, a); chk("R2 read addr ack", 16'(a), 16'h1);
    read_word(w, 1'b0);
    bus_stop();
    chk("R7 read high then low", w, 16'h0284);
  endtask

  task automatic t_burst();
    logic a;
    logic [15:0] w;
    set_ptr("burst", 8'h30);
    send_word("burst", 16'h1234);
    send_word("burst", 16'hBEEF);
    send_word("burst", 16'h0F0F);
    bus_stop();
    chk("R6 burst word 0", mem[8'h30], 16'h1234);
    chk("R6 burst word 1", mem[8'h31], 16'hBEEF);
    chk("R6 burst word 2", mem[8'h32], 16'h0F0F);
    set_ptr("rburst", 8'h30);
    bus_start();
    wr_byte(8'hBB, a);
    read_word(w, 1'b1); chk("R8 read burst 0", w, 16'h1234);
    read_word(w, 1'b1); chk("R8 read burst 1", w, 16'hBEEF);
    read_word(w, 1'b0); chk("R8 read burst 2", w, 16'h0F0F);
    bus_stop();
  endtask

  task automatic t_lone_byte();
    logic a;
    logic [15:0] w;
    int c0 = wr_cnt;
    set_ptr("lone", 8'h20);
    wr_byte(8'h55, a);
    bus_stop();
    tick(5);
    chk("R5 lone byte then stop, no strobe", 16'(wr_cnt - c0), 16'h0);
    chk("R5 lone byte register kept", mem[8'h20], init_val(8'h20));
    set_ptr("abort", 8'h40);
    wr_byte(8'h77, a);
    bus_start();
    wr_byte(8'hBB, a);
    read_word(w, 1'b0);
    bus_stop();
    chk("R5 repeated start drops half word", w, init_val(8'h40));
    chk("R5 no strobe on aborted word", 16'(wr_cnt - c0), 16'h0);
  endtask

  task automatic t_wrap();
    set_ptr("wrap", 8'hFF);
    send_word("wrap", 16'hAAAA);
    send_word("wrap", 16'h5555);
    bus_stop();
    chk("R10 word at 0xFF", mem[8'hFF], 16'hAAAA);
    chk("R10 pointer wrapped to 0x00", mem[8'h00], 16'h5555);
  endtask

  task automatic t_bad_addr();
    logic a1, a2, a3, a4;
    int c0 = wr_cnt;
    bus_start();
    wr_byte(8'hA0, a1);
    wr_byte(8'h10, a2);
    wr_byte(8'h12, a3);
    wr_byte(8'h34, a4);
    bus_stop();
    chk("R3 no ack on foreign address", {12'h0, a1, a2, a3, a4}, 16'h0);
    chk("R3 no strobe on foreign transfer", 16'(wr_cnt - c0), 16'h0);
    bus_start();
    wr_byte(8'hBC, a1);
    bus_stop();
    chk("R3 no ack on near-miss address", 16'(a1), 16'h0);
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] extra;
    logic [15:0] w;
    set_ptr("nack", 8'h31);
    bus_start();
    wr_byte(8'hBB, a);
    read_word(w, 1'b0);
    chk("R7 read after pointer 0x31", w, 16'hBEEF);
    tick(2);
    chk("R9 released after NACK", 16'(sda_oe), 16'h0);
    rd_byte(extra, 1'b0);
    chk("R9 line stays released", 16'(extra), 16'h00FF);
    bus_stop();
    bus_start();
    wr_byte(8'hBB, a);
    read_word(w, 1'b0);
    bus_stop();
    chk("R8 pointer stepped past NACKed word", w, 16'h0F0F);
  endtask

  initial begin
    tick(5);
    t_reset();
    tick(20);
    t_write_one();
    t_read_one();
    t_burst();
    t_lone_byte();
    t_wrap();
    t_bad_addr();
    t_nack_release();
    tick(20);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule